// File: doc/BRIEF.md
# Wait-State Bus Cycle Sequencer

This block is the processor-side bus interface of a 16-bit core. Each memory or I/O transfer requested on a simple start/address/data interface is run as four clock states. T1 drives the address with a one-cycle latch-enable pulse. T2 and T3 hold the read or write strobe. T4 closes the transfer and returns the result. A slow device stretches the transfer by holding the active-high ready input low. Each low sample, taken at the end of T2 and again at the end of every wait state, adds one wait state (TW) between T2 and T3.

Byte-lane selection is encoded by an active-low byte-high-enable together with address bit 0. A word request at an odd address is refused with an error pulse and is not split into two transfers. An external master such as a DMA engine can take the buses through a request/acknowledge pair. The request is synchronised and only examined when no transfer is in flight. Once it is granted, the address, data and control outputs are released to high impedance.

Top module: `bus_cycle_seq`

## Requirements
- R1: An accepted request produces, counted in clock cycles from the accepting edge: one cycle of `ale` high with the address driven (T1), then the strobe (`rd_n` for reads, `wr_n` for writes) low from T2 through T3, then one cycle with the strobe high and `req_done` high (T4). A zero-wait transfer therefore takes 4 cycles.
- R2: `bus_ready` is sampled only at the end of T2 and at the end of each TW. The strobe stays low for 2 + N cycles, where N is the number of low samples. Ready being low during T1 or T3 has no effect on the length of the transfer.
- R3: `bus_mio` is 1 for memory transfers (`req_mem`=1) and 0 for I/O transfers during the transfer.
- R4: Lane encoding is as follows. A word transfer gives `bus_bhe_n`=0 with address bit 0 = 0. A byte at an odd address gives `bus_bhe_n`=0 with bit 0 = 1 and uses lane [15:8]. A byte at an even address gives `bus_bhe_n`=1 with bit 0 = 0 and uses lane [7:0].
- R5: A word request with address bit 0 = 1 starts no transfer (`ale` stays 0, address not driven). It raises `req_err` for exactly one cycle, after the accepting edge.
- R6: Read data is captured from `bus_din` at the transition from T3 to T4 and presented on `req_rdata` while `req_done` is high. A byte read returns the selected lane in bits [7:0] with bits [15:8] zero.
- R7: For writes, `bus_dout_oe` is 1 from T2 through T4. A byte write places `req_wdata[7:0]` on the selected lane.
- R8: `hold_req` passes through two flip-flops. Raised while idle, it gives `hold_ack`=1 after the third rising edge, not earlier. While `hold_ack` is 1, `bus_addr_oe`, `ctl_oe` and `bus_dout_oe` are 0 and `req_start` is ignored.
- R9: A hold request raised during a transfer never shortens it. `hold_ack` stays 0 until T4 has completed and rises in the cycle right after `req_done`.
- R10: After `hold_req` falls, `hold_ack` drops after the third rising edge. `req_idle` then rises and a new request is accepted.
- R11: After reset the block is idle: `req_idle`=1, `rd_n`=`wr_n`=1, `ale`=0, `hold_ack`=0, and the address and data outputs are not enabled.
- R12: `rd_n` and `wr_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start a transfer (taken when `req_idle` is 1) |
| req_addr | input | AW | Transfer address |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit, 0 = byte |
| req_wdata | input | 16 | Write data (byte in [7:0]) |
| req_idle | output | 1 | Request interface can accept a start |
| req_done | output | 1 | One-cycle completion pulse (T4) |
| req_rdata | output | 16 | Read result, valid with `req_done` |
| req_err | output | 1 | One-cycle pulse for a refused odd word request |
| bus_ready | input | 1 | Active-high device ready |
| hold_req | input | 1 | External master bus request |
| hold_ack | output | 1 | Buses released to external master |
| bus_addr | output | AW | Address bus |
| bus_addr_oe | output | 1 | Address bus output enable |
| bus_bhe_n | output | 1 | Active-low upper lane enable |
| bus_mio | output | 1 | Memory (1) / I/O (0) select |
| ale | output | 1 | Address latch enable pulse in T1 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ctl_oe | output | 1 | Enable for `bus_bhe_n`, `bus_mio`, `ale`, `rd_n`, `wr_n` |
| bus_dout | output | 16 | Data bus out |
| bus_dout_oe | output | 1 | Data bus output enable |
| bus_din | input | 16 | Data bus in |

## Verification
Transfers are run with 0, 1, 3 and 5 low ready samples. Ready is also pulled low during T1 and T3, which separates sampling at the end of T2 and TW from sampling in every state. Word, upper-byte and lower-byte transfers use a data pattern whose two halves differ, so a swapped or unzeroed lane shows up. Hold is raised once while idle, to time the synchroniser, and once during a long wait-stretched read, to show that the grant waits for T4. A start pulse during hold and an odd word request check the two paths that must not begin a transfer.

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_start,
  input  logic [AW-1:0] req_addr,
  input  logic          req_mem,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [15:0]   req_wdata,
  output logic          req_idle,
  output logic          req_done,
  output logic [15:0]   req_rdata,
  output logic          req_err,
  input  logic          bus_ready,
  input  logic          hold_req,
  output logic          hold_ack,
  output logic [AW-1:0] bus_addr,
  output logic          bus_addr_oe,
  output logic          bus_bhe_n,
  output logic          bus_mio,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          ctl_oe,
  output logic [15:0]   bus_dout,
  output logic          bus_dout_oe,
  input  logic [15:0]   bus_din
);

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_TW, S_T3, S_T4, S_HOLD} st_t;

  st_t           st;
  logic [1:0]    hsync;
  logic          wr_q, word_q, mem_q, err_q;
  logic [AW-1:0] addr_q;
  logic [15:0]   wd_q, rd_q;

  wire hold_s = hsync[1];
  wire accept = (st == S_IDLE) && !hold_s && req_start;
  wire bad    = req_word && req_addr[0];
  wire strobe = (st == S_T2) || (st == S_TW) || (st == S_T3);
  wire in_cyc = strobe || (st == S_T1) || (st == S_T4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      hsync  <= '0;
      err_q  <= 1'b0;
      wr_q   <= 1'b0;
      word_q <= 1'b0;
      mem_q  <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      hsync <= {hsync[0], hold_req};
      err_q <= accept && bad;
      case (st)
        S_IDLE: begin
          if (hold_s) st <= S_HOLD;
          else if (accept && !bad) begin
            st     <= S_T1;
            addr_q <= req_addr;
            wr_q   <= req_write;
            word_q <= req_word;
            mem_q  <= req_mem;
            if (req_word)         wd_q <= req_wdata;
            else if (req_addr[0]) wd_q <= {req_wdata[7:0], 8'h00};
            else                  wd_q <= {8'h00, req_wdata[7:0]};
          end
        end
        S_T1: st <= S_T2;
        S_T2, S_TW: st <= bus_ready ? S_T3 : S_TW;
        S_T3: begin
          st <= S_T4;
          if (!wr_q) begin
            if (word_q)         rd_q <= bus_din;
            else if (addr_q[0]) rd_q <= {8'h00, bus_din[15:8]};
            else                rd_q <= {8'h00, bus_din[7:0]};
          end
        end
        S_T4:   st <= hold_s ? S_HOLD : S_IDLE;
        S_HOLD: if (!hold_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_idle    = (st == S_IDLE) && !hold_s;
  assign req_done    = (st == S_T4);
  assign req_rdata   = rd_q;
  assign req_err     = err_q;
  assign hold_ack    = (st == S_HOLD);
  assign bus_addr    = addr_q;
  assign bus_addr_oe = in_cyc;
  assign bus_bhe_n   = !(word_q || addr_q[0]);
  assign bus_mio     = mem_q;
  assign ale         = (st == S_T1);
  assign rd_n        = !(strobe && !wr_q);
  assign wr_n        = !(strobe && wr_q);
  assign ctl_oe      = (st != S_HOLD);
  assign bus_dout    = wd_q;
  assign bus_dout_oe = wr_q && (strobe || (st == S_T4));

endmodule

module bus_cycle_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic req_done,
  input logic hold_ack,
  input logic bus_addr_oe,
  input logic ctl_oe,
  input logic bus_dout_oe
);

  a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  a_r1_strobe_follows_ale: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!rd_n || !wr_n));

  a_r1_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> (rd_n && wr_n && $past(!rd_n || !wr_n)));

  a_r8_hold_released: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (!bus_addr_oe && !ctl_oe && !bus_dout_oe));

  a_r9_grant_outside_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> ($past(rd_n) && $past(wr_n) && !$past(ale)));

endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .req_done(req_done), .hold_ack(hold_ack), .bus_addr_oe(bus_addr_oe),
  .ctl_oe(ctl_oe), .bus_dout_oe(bus_dout_oe)
);

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_start = 0, req_mem = 0, req_write = 0, req_word = 0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0, bus_din = '0;
  logic bus_ready = 0, hold_req = 0;
  logic req_idle, req_done, req_err, hold_ack, bus_addr_oe, bus_bhe_n, bus_mio;
  logic ale, rd_n, wr_n, ctl_oe, bus_dout_oe;
  logic [15:0] req_rdata, bus_dout;
  logic [AW-1:0] bus_addr;
  int total = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_seq #(.AW(AW)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_xfer(input bit mem, input bit wr, input bit word, input logic [AW-1:0] addr,
                          input logic [15:0] wdata, input int nwait, input logic [15:0] din,
                          input logic [15:0] exp_rd, input bit raise_hold, input string tag);
    int cyc, slow;
    logic [15:0] exp_dout;
    bit exp_bhe;
    exp_bhe  = !(word || addr[0]);
    exp_dout = word ? wdata : (addr[0] ? {wdata[7:0], 8'h00} : {8'h00, wdata[7:0]});
    @(negedge clk);
    req_mem = mem; req_write = wr; req_word = word; req_addr = addr;
    req_wdata = wdata; bus_din = din; bus_ready = 0; req_start = 1;
    @(negedge clk);
    req_start = 0;
    if (raise_hold) hold_req = 1;
    chk(ale && bus_addr_oe && bus_addr == addr, {tag, " R1 T1 address/ale"}, {ale, bus_addr_oe}, 2'b11);
    chk(bus_bhe_n == exp_bhe, {tag, " R4 bhe_n"}, bus_bhe_n, exp_bhe);
    chk(bus_mio == mem, {tag, " R3 mio"}, bus_mio, mem);
    cyc = 1; slow = 0;
    while (cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (hold_ack) chk(0, {tag, " R9 hold_ack inside transfer"}, hold_ack, 0);
      if (req_done) break;
      if (!rd_n || !wr_n) begin
        slow++;
        if (slow == 1 && wr) chk(bus_dout_oe && bus_dout == exp_dout, {tag, " R7 write lane"}, bus_dout, exp_dout);
        bus_ready = (slow > nwait) && (slow <= nwait + 1);
      end
    end
    chk(cyc == 4 + nwait, {tag, " R1 R2 cycle length"}, cyc, 4 + nwait);
    chk(slow == 2 + nwait, {tag, " R2 strobe cycles"}, slow, 2 + nwait);
    chk(rd_n && wr_n, {tag, " R1 strobe high in T4"}, {rd_n, wr_n}, 2'b11);
    if (wr) chk(bus_dout_oe, {tag, " R7 data driven in T4"}, bus_dout_oe, 1);
    else chk(req_rdata == exp_rd, {tag, " R6 read data"}, req_rdata, exp_rd);
    bus_ready = 0;
  endtask

  task automatic test_reset();
    chk(req_idle && rd_n && wr_n && !ale && !hold_ack && !bus_addr_oe && !bus_dout_oe,
        "R11 reset state", {req_idle, rd_n, wr_n, ale, hold_ack, bus_addr_oe, bus_dout_oe}, 7'b1110000);
  endtask

  task automatic test_odd_word();
    @(negedge clk);
    req_word = 1; req_write = 0; req_addr = 20'h00101; req_start = 1;
    @(negedge clk);
    req_start = 0;
    chk(req_err && !ale && !bus_addr_oe, "R5 odd word refused", {req_err, ale, bus_addr_oe}, 3'b100);
    @(negedge clk);
    chk(!req_err && !ale && req_idle, "R5 error one cycle", {req_err, ale, req_idle}, 3'b001);
  endtask

  task automatic test_hold_idle();
    @(negedge clk);
    hold_req = 1;
    @(negedge clk); @(negedge clk);
    chk(!hold_ack, "R8 ack not before third edge", hold_ack, 0);
    @(negedge clk);
    chk(hold_ack && !bus_addr_oe && !ctl_oe && !bus_dout_oe, "R8 hold grant tri-state",
        {hold_ack, bus_addr_oe, ctl_oe, bus_dout_oe}, 4'b1000);
    req_start = 1; req_word = 0; req_addr = 20'h00010;
    @(negedge clk);
    req_start = 0;
    chk(!ale && hold_ack, "R8 start ignored in hold", {ale, hold_ack}, 2'b01);
    release_hold();
  endtask

  task automatic release_hold();
    hold_req = 0;
    @(negedge clk); @(negedge clk);
    chk(hold_ack, "R10 ack held through sync", hold_ack, 1);
    @(negedge clk);
    chk(!hold_ack && req_idle && ctl_oe, "R10 buses reclaimed", {hold_ack, req_idle, ctl_oe}, 3'b011);
  endtask

  task automatic test_hold_midcycle();
    run_xfer(1, 0, 1, 20'h02000, 16'h0, 6, 16'h1E2D, 16'h1E2D, 1, "hold-mid");
    @(negedge clk);
    chk(hold_ack && !bus_addr_oe && !ctl_oe, "R9 grant right after T4", {hold_ack, bus_addr_oe, ctl_oe}, 3'b100);
    release_hold();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    test_reset();
    rst_n = 1;
    run_xfer(1, 0, 1, 20'h01234 & ~20'h1, 16'h0, 0, 16'hA55A, 16'hA55A, 0, "word-read");
    run_xfer(0, 0, 0, 20'h00043, 16'h0, 3, 16'hA55A, 16'h00A5, 0, "upper-byte-io-read");
    run_xfer(1, 0, 0, 20'h00044, 16'h0, 1, 16'hA55A, 16'h005A, 0, "lower-byte-read");
    run_xfer(1, 1, 0, 20'h00081, 16'h773C, 1, 16'h0, 16'h0, 0, "upper-byte-write");
    run_xfer(0, 1, 1, 20'h00200, 16'hBEEF, 5, 16'h0, 16'h0, 0, "word-io-write");
    test_odd_word();
    test_hold_idle();
    test_hold_midcycle();
    run_xfer(1, 0, 0, 20'h00300, 16'h0, 0, 16'hC381, 16'h0081, 0, "after-release");
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule